// File: doc/BRIEF.md
# Bus Master Request Hold Controller

This block drives the active-low request line that an internal bus master on one bridge port presents to the bus arbiter. While the outbound transaction FIFO reports pending work, the controller asks for the bus. When the request is withdrawn depends on a per-port mode bit, `hold_long`.

With the mode bit cleared, the request is dropped as soon as the master owns the bus and has started its transaction, which is the cycle in which grant and FRAME_L are both seen low. With the mode bit set, the request stays asserted across back-to-back transactions. It is dropped only when the FIFO empties, when the target terminates the transfer, or when software clears the mode bit. After every release the line stays deasserted for at least `GAP` clocks. If work is still pending at the end of that interval, the request is raised again at once.

The mode bit is held in a configuration register outside this block, and that register resets it to 1 (long hold). Arbitration and the data phases are handled elsewhere. All pins are plain control levels, so no valid/ready handshake is involved.

Top module: `req_hold_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `req_l` is 1 (request deasserted).
- R2: From idle, `req_l` goes to 0 in the cycle after a clock edge that samples `fifo_pending`=1. `req_l` never falls unless `fifo_pending` was 1 at the previous edge.
- R3: With `hold_long`=0, an edge that samples `req_l`=0, `bus_gnt_l`=0 and `frame_l`=0 makes `req_l` 1 in the following cycle.
- R4: With `hold_long`=1, once grant and FRAME_L have been sampled low, `req_l` stays 0 while `fifo_pending`=1 and `tgt_term`=0, whatever `frame_l` and `bus_gnt_l` do.
- R5: An edge that samples `req_l`=0 and `fifo_pending`=0 makes `req_l` 1 in the following cycle.
- R6: An edge that samples `req_l`=0 and `tgt_term`=1 makes `req_l` 1 in the following cycle.
- R7: After any release, `req_l` stays 1 for exactly `GAP` cycles when `fifo_pending` stays high, and for at least `GAP` cycles otherwise.
- R8: Clearing `hold_long` while the request is held after the transaction has started releases `req_l` in the following cycle.
- R9: Before grant, FRAME_L seen low while `bus_gnt_l`=1 belongs to another master. It has no effect, and `req_l` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_pending | input | 1 | Outbound FIFO holds at least one transaction |
| bus_gnt_l | input | 1 | Arbiter grant, active low |
| frame_l | input | 1 | Observed FRAME_L, active low |
| tgt_term | input | 1 | Target terminated the current transfer (retry/disconnect/abort) |
| hold_long | input | 1 | Mode: 1 keeps the request across transactions, 0 drops it at FRAME_L |
| req_l | output | 1 | Bus request to the arbiter, active low |

## Verification
The bench targets the following corner cases, and each one exposes a particular mistake:
- **Pending work at the moment of release.** A controller that ignores the hold-off re-requests one cycle early. One that forgets to re-request stalls until a fresh pending edge.
- **FRAME_L low without grant.** A design that decodes FRAME_L alone drops or latches ownership for another master's transaction.
- **Mode bit changed mid-hold.** A design that samples the bit only at transaction start keeps the bus held after software has asked for short hold.
- **Termination and emptying in the same cycle as grant.** A design with the wrong priority moves into the held state and keeps the bus for a cycle too long.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_OWN  = 2'd2,
    ST_REL  = 2'd3
  } rhc_state_e;
endpackage

// File: rtl/rhc_holdoff.sv
module rhc_holdoff #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = (GAP < 2) ? 1 : $clog2(GAP);
  localparam logic [CW-1:0] LOADV = CW'(GAP - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= LOADV;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/rhc_fsm.sv
module rhc_fsm
  import rhc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_pending,
  input  logic       bus_gnt_l,
  input  logic       frame_l,
  input  logic       tgt_term,
  input  logic       hold_long,
  input  logic       quiet_done,
  output logic       quiet_start,
  output rhc_state_e state
);
  rhc_state_e nxt;
  logic       started;

  assign started = !bus_gnt_l && !frame_l;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (fifo_pending) nxt = ST_ASK;
      ST_ASK: begin
        if (!fifo_pending || tgt_term)  nxt = ST_REL;
        else if (started)               nxt = hold_long ? ST_OWN : ST_REL;
      end
      ST_OWN:  if (!fifo_pending || tgt_term || !hold_long) nxt = ST_REL;
      ST_REL:  if (quiet_done) nxt = fifo_pending ? ST_ASK : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign quiet_start = (nxt == ST_REL) && (state != ST_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/req_hold_ctrl.sv
module req_hold_ctrl
  import rhc_pkg::*;
#(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_pending,
  input  logic bus_gnt_l,
  input  logic frame_l,
  input  logic tgt_term,
  input  logic hold_long,
  output logic req_l
);
  rhc_state_e state;
  logic       quiet_start;
  logic       quiet_done;

  rhc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fifo_pending(fifo_pending),
    .bus_gnt_l(bus_gnt_l), .frame_l(frame_l), .tgt_term(tgt_term),
    .hold_long(hold_long), .quiet_done(quiet_done),
    .quiet_start(quiet_start), .state(state)
  );

  rhc_holdoff #(.GAP(GAP)) u_quiet (
    .clk(clk), .rst_n(rst_n), .start(quiet_start), .done(quiet_done)
  );

  assign req_l = !((state == ST_ASK) || (state == ST_OWN));
endmodule

// File: rtl/rhc_chk.sv
module rhc_chk #(
  parameter int GAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic fifo_pending,
  input logic bus_gnt_l,
  input logic frame_l,
  input logic tgt_term,
  input logic hold_long,
  input logic req_l
);
  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hi_cnt <= GAP;
    else if (!req_l)             hi_cnt <= 0;
    else if (hi_cnt < GAP)       hi_cnt <= hi_cnt + 1;
  end

  p_fall_needs_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_l) |-> $past(fifo_pending));

  p_short_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_l && !bus_gnt_l && !frame_l && !hold_long) |=> req_l);

  p_long_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_l && !bus_gnt_l && !frame_l && hold_long && fifo_pending && !tgt_term) |=> !req_l);

  p_drain_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_l && !fifo_pending) |=> req_l);

  p_term_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_l && tgt_term) |=> req_l);

  p_quiet_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_l) |-> (hi_cnt >= GAP));

  p_foreign_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_l && bus_gnt_l && fifo_pending && !tgt_term && hold_long) |=> !req_l);
endmodule

bind req_hold_ctrl rhc_chk #(.GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_pending(fifo_pending),
  .bus_gnt_l(bus_gnt_l), .frame_l(frame_l), .tgt_term(tgt_term),
  .hold_long(hold_long), .req_l(req_l)
);

// File: tb/sim_req_hold_ctrl.sv
module sim_req_hold_ctrl;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pend = 1'b0, gnt_l = 1'b1, frm_l = 1'b1, term = 1'b0, hold = 1'b1;
  logic req_l;

  int vectors = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural model: asking / owning flags plus a quiet countdown
  bit asking, owning;
  int quiet;

  always #2 clk = ~clk;

  req_hold_ctrl #(.GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_pending(pend), .bus_gnt_l(gnt_l),
    .frame_l(frm_l), .tgt_term(term), .hold_long(hold), .req_l(req_l)
  );

  function automatic bit exp_req_l();
    return !(asking || owning);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asking = 0; owning = 0; quiet = 0;
    end else if (asking || owning) begin
      bool_release();
    end else if (quiet > 0) begin
      quiet = quiet - 1;
      if (quiet == 0 && pend) asking = 1;
    end else if (pend) begin
      asking = 1;
    end
  end

  task automatic bool_release();
    bit drop;
    drop = !pend || term;
    if (asking && !drop && !gnt_l && !frm_l) begin
      if (hold) begin asking = 0; owning = 1; end
      else drop = 1;
    end else if (owning && !hold) drop = 1;
    if (drop) begin
      asking = 0; owning = 0;
      quiet = GAP;
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (req_l !== exp_req_l()) begin
        errors++;
        $display("FAIL %s t=%0t req_l actual=%b expected=%b", tag, $time, req_l, exp_req_l());
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(2);                                   // R1: idle, no pending
    tag = "R2";  pend = 1; cyc(2);            // R2: request raised
    tag = "R9";  frm_l = 0; cyc(3);           // R9: foreign FRAME_L, no grant
    tag = "R4";  gnt_l = 0; cyc(1);
    frm_l = 1; cyc(1); frm_l = 0; cyc(1); gnt_l = 1; frm_l = 1; cyc(3); // R4 hold
    tag = "R5";  pend = 0; cyc(4);            // R5 drain release
    tag = "R7";  pend = 1; gnt_l = 0; frm_l = 0; cyc(3);
    pend = 0; cyc(1); pend = 1; cyc(5);       // R7: back-to-back re-request after GAP
    tag = "R6";  term = 1; cyc(1); term = 0; cyc(5);  // R6
    tag = "R8";  hold = 0; cyc(1); hold = 1; cyc(3);  // R8 arrives on own
    hold = 0; cyc(4);                                 // R8 clear during own
    tag = "R3";  hold = 0; gnt_l = 1; frm_l = 1; cyc(3);
    gnt_l = 0; frm_l = 0; cyc(1); gnt_l = 1; frm_l = 1; cyc(6); // R3 short mode
    tag = "R5";  gnt_l = 1; cyc(2); pend = 0; cyc(4);  // R5 withdraw before grant
    tag = "R1";  rst_n = 0; pend = 1; cyc(2); rst_n = 1; cyc(1);
    tag = "R2 R3 R4 R5 R6 R7 R8 R9 random";
    for (int i = 0; i < 4000; i++) begin
      pend  = ($urandom_range(0, 9) != 0);
      gnt_l = $urandom_range(0, 1);
      frm_l = $urandom_range(0, 1);
      term  = ($urandom_range(0, 15) == 0);
      hold  = ($urandom_range(0, 7) != 0);
      cyc(1);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule